// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects a clocked system to an external asynchronous static RAM of 131072 bytes. A requester hands over one read or one write at a time on a valid/ready handshake, with a 17-bit word address and 8-bit write data. The block then plays out the strobe sequence the RAM needs. It drives the active-low chip select, write strobe and output-enable, and it drives the shared data pins through separate out, in and drive-enable signals. The three-state pad itself sits at the chip edge.

Every wait is a whole number of clock cycles, worked out at elaboration from nanosecond limits and the clock period. There are four such waits: access time, write pulse, data setup and bus release. A write holds its data for one cycle after the write strobe and chip select rise together, so the RAM latches stable data. Read data is captured on the last wait cycle and handed back with a one-cycle valid pulse. Between any period in which the controller drives the data pins and any period in which the RAM drives them, the block keeps a guaranteed number of cycles with neither side driving.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, chip select, write strobe and output-enable are high (inactive), the data drive-enable is low, `req_ready` is high and `rdata_valid` is low.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the transfer ends. It stays low for 1 + W + 1 + T cycles, where W is the read wait (reads) or the write pulse (writes) and T is the bus release count: 7 cycles at the defaults.
- R3: A write drives chip select low for one setup cycle and then for the write pulse. The write strobe is low only during the pulse, for exactly max(ceil(TWP/clk), ceil(TDS/clk)) cycles (3 at the defaults). Output-enable stays high for the whole write.
- R4: The RAM address is loaded when a request is taken. It does not change while chip select is low, and chip select is already low with the same address on the cycle before the write strobe falls.
- R5: Write data is driven from the setup cycle through one hold cycle after the write strobe rises, and it does not change while it is driven.
- R6: A read holds chip select low with the write strobe high for one setup cycle, then holds output-enable low for ceil(TACC/clk) cycles (3 at the defaults). The data pins are sampled at the end of the last of those cycles. `rdata` carries that byte with a one-cycle `rdata_valid` pulse, visible 1 + ceil(TACC/clk) cycles after the accepting edge.
- R7: The data drive-enable is never high while output-enable is low, so the controller and the RAM never drive the data pins together.
- R8: At least ceil(TTURN/clk) cycles (2 at the defaults) with drive-enable low and output-enable high separate a fall of output-enable from the end of the last driven cycle, and a rise of drive-enable from the end of the last output-enable low cycle.
- R9: Each cycle count is the nanosecond value divided by the clock period and rounded up, with a floor of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte read back |
| rdata_valid | output | 1 | One-cycle pulse marking `rdata` |
| sram_addr | output | 17 | Address pins of the RAM |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | RAM output-enable, active low |
| sram_dq_out | output | 8 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Drive-enable for `sram_dq_out` |
| sram_dq_in | input | 8 | Data seen on the shared pins |

## Verification
The read result falls due exactly 1 + ceil(TACC/clk) cycles after the edge that takes the request, which is 4 cycles at 250 MHz. `req_ready` returns exactly 7 cycles after that edge for either direction. The bench stamps each request with a cycle counter, queues the expected byte and its due cycle, and checks both on the falling edge where `rdata_valid` is seen. The RAM model in the bench runs on falling edges, between register updates. It supplies valid read data only once the address has been stable long enough and output-enable has been low long enough. It commits a write on the cycle the strobe overlap ends. It measures strobe lengths, address and data stability, and idle gaps between drivers against the cycle counts in the requirements.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SETUP    = 3'd1,
    ST_RD_WAIT  = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_HOLD     = 3'd4,
    ST_TURN     = 3'd5
  } seq_state_t;

  // R9: round a time up to whole clock cycles, never below one
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_wait_timer.sv
module asram_wait_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int TACC_C  = 3,
  parameter int TWP_C   = 3,
  parameter int TTURN_C = 2,
  parameter int CW      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  output logic       req_ready,
  output logic       accept,
  output logic       wr_d,
  output seq_state_t state_d,
  output logic       capture
);

  seq_state_t    state_q;
  logic          is_wr_q;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign wr_d      = accept ? req_write : is_wr_q;
  assign capture   = (state_q == ST_RD_WAIT) && tmr_zero;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (req_valid) state_d = ST_SETUP;
      ST_SETUP:    state_d = is_wr_q ? ST_WR_PULSE : ST_RD_WAIT;
      ST_RD_WAIT:  if (tmr_zero) state_d = ST_HOLD;
      ST_WR_PULSE: if (tmr_zero) state_d = ST_HOLD;
      ST_HOLD:     state_d = ST_TURN;
      ST_TURN:     if (tmr_zero) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      ST_RD_WAIT:  tmr_val = CW'(TACC_C - 1);
      ST_WR_PULSE: tmr_val = CW'(TWP_C - 1);
      ST_TURN:     tmr_val = CW'(TTURN_C - 1);
      default:     tmr_val = '0;
    endcase
  end

  asram_wait_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) is_wr_q <= req_write;
    end
  end

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready); // R2

  AST_CAPTURE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    capture |-> !is_wr_q); // R6

endmodule

// File: rtl/asram_io_regs.sv
module asram_io_regs
  import asram_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int TTURN_C = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  seq_state_t    state_d,
  input  logic          wr_d,
  input  logic          capture,
  input  logic [DW-1:0] sram_dq_in,
  output logic [AW-1:0] sram_addr,
  output logic          sram_cs_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  output logic [DW-1:0] rdata,
  output logic          rdata_valid
);

  logic cs_d, we_d, oe_d, drv_d;
  int unsigned gap_q;

  always_comb begin
    cs_d  = (state_d == ST_SETUP) || (state_d == ST_RD_WAIT) || (state_d == ST_WR_PULSE);
    we_d  = (state_d == ST_WR_PULSE);
    oe_d  = (state_d == ST_RD_WAIT);
    drv_d = wr_d && ((state_d == ST_SETUP) || (state_d == ST_WR_PULSE) ||
                     (state_d == ST_HOLD));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_cs_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      if (accept) begin
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
      end
      sram_cs_n   <= !cs_d;
      sram_we_n   <= !we_d;
      sram_oe_n   <= !oe_d;
      sram_dq_oe  <= drv_d;
      if (capture) rdata <= sram_dq_in;
      rdata_valid <= capture;
    end
  end

  // cycles with neither side on the data pins, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= 32'd255;
    end else if (sram_dq_oe || !sram_oe_n) begin
      gap_q <= '0;
    end else if (gap_q != 32'd255) begin
      gap_q <= gap_q + 1;
    end
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
    !(sram_dq_oe && !sram_oe_n)); // R7

  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_cs_n); // R3

  AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_oe_n); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr)); // R4

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out)); // R5

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |=> !rdata_valid); // R6

  AST_GAP_BEFORE_OE: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_oe_n) |-> (gap_q >= TTURN_C)); // R8

  AST_GAP_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (gap_q >= TTURN_C)); // R8

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 4000,
  parameter int TACC_PS  = 10000,
  parameter int TWP_PS   = 9000,
  parameter int TDS_PS   = 6000,
  parameter int TTURN_PS = 7000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  // R9: cycle counts from nanosecond limits
  localparam int TACC_C  = int'(ps_to_cycles(TACC_PS, CLK_PS));
  localparam int TWP_C   = int'(max_u(ps_to_cycles(TWP_PS, CLK_PS),
                                      ps_to_cycles(TDS_PS, CLK_PS)));
  localparam int TTURN_C = int'(ps_to_cycles(TTURN_PS, CLK_PS));
  localparam int MAX_C   = int'(max_u(max_u(TACC_C, TWP_C), TTURN_C));
  localparam int CW      = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  logic       accept;
  logic       wr_d;
  logic       capture;
  seq_state_t state_d;

  asram_seq #(
    .TACC_C  (TACC_C),
    .TWP_C   (TWP_C),
    .TTURN_C (TTURN_C),
    .CW      (CW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .wr_d      (wr_d),
    .state_d   (state_d),
    .capture   (capture)
  );

  asram_io_regs #(
    .AW      (ADDR_W),
    .DW      (DATA_W),
    .TTURN_C (TTURN_C)
  ) u_io (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .state_d     (state_d),
    .wr_d        (wr_d),
    .capture     (capture),
    .sram_dq_in  (sram_dq_in),
    .sram_addr   (sram_addr),
    .sram_cs_n   (sram_cs_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .rdata       (rdata),
    .rdata_valid (rdata_valid)
  );

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int CLK_PS  = 4000;
  localparam int TACC_C  = 3;  // ceil(10/4)
  localparam int TWP_C   = 3;  // max(ceil(9/4), ceil(6/4))
  localparam int TTURN_C = 2;  // ceil(7/4)
  localparam int BUSY_C  = 1 + 3 + 1 + TTURN_C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr  = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rdata_valid;
  logic [7:0]  rdata;
  logic [16:0] sram_addr;
  logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  sram_dq_out, sram_dq_in;

  always #2ns clk = ~clk;

  asram_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rdata(rdata), .rdata_valid(rdata_valid), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] init_byte(input logic [16:0] a);
    return a[7:0] ^ {a[16:15], a[13:8]} ^ 8'h3C;
  endfunction

  // ---------------- RAM model (acts on falling edges) ----------------
  logic [7:0] mem [int];
  logic [7:0] model_q = 8'hEE;
  logic       model_drv;
  int acc_n = 0, oe_n_len = 0, wr_len = 0, gap = 100;
  logic        p_cs_n = 1, p_we_n = 1, p_oe_n = 1, p_drv = 0, p_ov = 0;
  logic [16:0] p_addr = '0;
  logic [7:0]  p_dq = '0;

  assign model_drv  = !sram_cs_n && !sram_oe_n && sram_we_n;
  assign sram_dq_in = model_drv ? model_q : 8'hA5;

  always @(negedge clk) begin
    if (rst) begin
      acc_n = 0; oe_n_len = 0; wr_len = 0; gap = 100;
      p_cs_n = 1; p_we_n = 1; p_oe_n = 1; p_drv = 0; p_ov = 0;
    end else begin
      logic ov;
      ov = !sram_cs_n && !sram_we_n;
      // R7 contention
      if (model_drv && sram_dq_oe) check(0, "R7 bus fight", 1, 0);
      if (!sram_we_n && !sram_oe_n) check(0, "R3 oe low in write", 0, 1);
      // R8 turnaround
      if (!sram_oe_n && p_oe_n) check(gap >= TTURN_C, "R8 gap before oe", gap, TTURN_C);
      if (sram_dq_oe && !p_drv) check(gap >= TTURN_C, "R8 gap before drive", gap, TTURN_C);
      gap = (sram_dq_oe || !sram_oe_n) ? 0 : gap + 1;
      // R4 setup and stability
      if (!sram_we_n && p_we_n)
        check(!p_cs_n && (p_addr == sram_addr), "R4 addr/cs before we", int'(p_cs_n), 0);
      if (ov) begin
        if (p_ov) begin
          check(sram_addr == p_addr, "R4 addr moved in write", int'(sram_addr), int'(p_addr));
          check(sram_dq_out == p_dq && sram_dq_oe, "R5 data moved in write",
                int'(sram_dq_out), int'(p_dq));
        end
        wr_len++;
      end else if (p_ov) begin
        mem[int'(p_addr)] = p_dq;
        check(wr_len == TWP_C, "R3 R9 write pulse length", wr_len, TWP_C);
        check(sram_dq_oe && sram_dq_out == p_dq, "R5 hold after we rise",
              int'(sram_dq_out), int'(p_dq));
        wr_len = 0;
      end
      // read access tracking
      if (!sram_cs_n && !p_cs_n && sram_addr == p_addr) acc_n++;
      else if (!sram_cs_n) acc_n = 1;
      else acc_n = 0;
      if (!sram_oe_n) oe_n_len++;
      else if (!p_oe_n) begin
        check(oe_n_len == TACC_C, "R6 R9 oe low length", oe_n_len, TACC_C);
        oe_n_len = 0;
      end
      if (acc_n * CLK_PS >= 10000 && oe_n_len * CLK_PS >= 5000)
        model_q = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : init_byte(sram_addr);
      else
        model_q = 8'hEE;
      p_cs_n = sram_cs_n; p_we_n = sram_we_n; p_oe_n = sram_oe_n;
      p_drv = sram_dq_oe; p_ov = ov; p_addr = sram_addr; p_dq = sram_dq_out;
    end
  end

  // ---------------- scoreboard ----------------
  logic [7:0] ref_mem [int];
  logic [7:0] exp_q [$];
  int         due_q [$];

  task automatic do_req(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int acc_cyc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    acc_cyc = cyc;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    check(!req_ready, "R2 busy after take", int'(req_ready), 0);
    if (wr) ref_mem[int'(a)] = d;
    else begin
      exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_byte(a));
      due_q.push_back(acc_cyc + 1 + TACC_C);
    end
    while (!req_ready) @(negedge clk);
    check(cyc - acc_cyc == BUSY_C, "R2 busy length", cyc - acc_cyc, BUSY_C);
  endtask

  always @(negedge clk) begin
    if (!rst && rdata_valid) begin
      if (exp_q.size() == 0) check(0, "R6 unexpected rdata_valid", 1, 0);
      else begin
        logic [7:0] e;
        int du;
        e = exp_q.pop_front();
        du = due_q.pop_front();
        check(rdata == e, "R6 read data", int'(rdata), int'(e));
        check(cyc == du, "R6 read latency", cyc, du);
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    check(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 strobes in reset",
          {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
    check(req_ready && !rdata_valid, "R1 handshake in reset",
          {req_ready, rdata_valid}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    check(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready,
          "R1 after reset", {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready},
          5'b11101);
    do_req(1'b0, 17'h12345, 8'h00);      // unwritten location
    do_req(1'b1, 17'h00000, 8'h11);
    do_req(1'b1, 17'h1FFFF, 8'hF0);      // top address
    do_req(1'b1, 17'h0AAAA, 8'h5A);
    do_req(1'b0, 17'h00000, 8'h00);
    do_req(1'b0, 17'h1FFFF, 8'h00);
    do_req(1'b0, 17'h0AAAA, 8'h00);
    do_req(1'b1, 17'h0AAAA, 8'hC3);      // overwrite, then read-back
    do_req(1'b0, 17'h0AAAA, 8'h00);
    do_req(1'b1, 17'h15555, 8'hFF);
    do_req(1'b0, 17'h15555, 8'h00);
    do_req(1'b1, 17'h00001, 8'h00);
    do_req(1'b0, 17'h00001, 8'h00);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule